// File: doc/BRIEF.md
# Serial Slave Front End with Pause and Strap Address

This block is the serial edge of a small register-based peripheral. It oversamples the serial clock, data, chip-select, pause and write-protect pins on a fast system clock. Data is taken on serial clock rising edges and driven back on falling edges. The block assembles received bits into bytes for the register layer above it.

The first byte of every transaction is a slave address. Its two low bits must match two strap inputs, and its upper bits must match a fixed parameter. A mismatch silences the block until chip-select is released. The pause input freezes the bit sequence without losing its contents, so a transaction can be suspended and later resumed at the same bit. After reset the block stays inert until it sees chip-select fall. The write-protect pin is passed up as a block flag. Opcode decoding, storage and the analog networks belong to other blocks.

Top module: `spi_hold_front`

## Requirements
- R1: SI is sampled on each SCK rising edge. Bits are assembled MSB first. After every 8th bit of an addressed data byte, rx_vld_o is high for exactly one clk_i cycle while rx_byte_o carries the byte.
- R2: The first byte after chip-select falls is the address. addr_match_o goes high only if that byte equals {ADDR_HI, addr_strap_i}, with addr_strap_i in bits 1:0. It stays high until cs_ni goes high. The address byte itself is not strobed on rx_vld_o.
- R3: After an address mismatch, no strobes occur and so_oe_o stays low until cs_ni goes high.
- R4: After reset, all traffic is ignored until cs_ni has been seen going from high to low. If cs_ni is low when reset ends, it must first go high.
- R5: While cs_ni is high, so_oe_o is low and the bit sequence is cleared. A cs_ni high in the middle of a byte discards the partial byte, and the next transaction starts at a fresh address byte.
- R6: A pause starts when hold_ni falls while SCK is low. During a pause, SCK edges are ignored and the received bits and bit position are kept. The pause ends when hold_ni rises while SCK is low, and shifting resumes at the same bit.
- R7: Transitions on hold_ni that occur while SCK is high do not change the pause state.
- R8: When addressed with rd_active_i high, so_o carries tx_byte_i MSB first. The byte is loaded on the SCK falling edge that ends each byte, and so_o moves to the next bit on each later falling edge.
- R9: so_oe_o is high only when the block is addressed, rd_active_i is high and no pause is active.
- R10: wp_block_o is the synchronized inverse of wp_ni. It is high when wp_ni is low, meaning writes to non-volatile data are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock (idle low) |
| si_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Active-low chip select |
| hold_ni | input | 1 | Active-low pause |
| addr_strap_i | input | 2 | Low two bits of the slave address |
| wp_ni | input | 1 | Active-low write-protect pin |
| rd_active_i | input | 1 | Register layer marks the transfer as a read |
| tx_byte_i | input | 8 | Byte to be shifted out on so_o |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (low means high impedance) |
| rx_byte_o | output | 8 | Received byte |
| rx_vld_o | output | 1 | One-cycle strobe for rx_byte_o |
| addr_match_o | output | 1 | Address byte matched in this transaction |
| wp_block_o | output | 1 | Non-volatile writes blocked |

## Verification
The bench first drives a full transaction while chip-select is held low across reset. A design that arms on the synchronizer's reset value would strobe bytes there. The bench pauses in the middle of bytes and toggles SCK and SI during the pause, so a design that keeps counting or loses contents would deliver corrupted bytes. It also drops and raises hold_ni while SCK is high, where a design that honours those edges would freeze and misalign bytes. Further cases cover mismatched straps, a chip-select release mid-byte, and read data sampled at every rising edge. Together they catch strobes after a mismatch, a bit counter that survives deselect, and transmit bytes loaded one edge late.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
package spi_hold_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  // bit positions inside the synchronized pin bundle
  localparam int PIN_SCK  = 0;
  localparam int PIN_HOLD = 1;
  localparam int PIN_CS   = 2;
  localparam int PIN_SI   = 3;
  localparam int PIN_WP   = 4;
  localparam int PIN_N    = 5;
  localparam int PIN_EDGE = 3;  // low bits that need edge detection
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter int EW = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  d_i,
  output logic [W-1:0]  q_o,
  output logic [EW-1:0] prev_o
);
  logic [W-1:0]  stg_q [STAGES];
  logic [EW-1:0] prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      prv_q <= RST_VAL[EW-1:0];
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prv_q <= stg_q[STAGES-1][EW-1:0];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign prev_o = prv_q;
endmodule

// File: rtl/spi_pause_ctl.sv
`timescale 1ns/1ps
module spi_pause_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sck_lvl_i,
  input  logic hold_lvl_i,
  input  logic hold_chg_i,
  output logic pause_o
);
  logic pause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pause_q <= 1'b0;
    else if (!sel_i)                    pause_q <= 1'b0;
    else if (hold_chg_i && !sck_lvl_i)  pause_q <= !hold_lvl_i;  // edges with SCK high are dropped
  end

  assign pause_o = pause_q;
endmodule

// File: rtl/spi_rx_shift.sv
`timescale 1ns/1ps
module spi_rx_shift
  import spi_hold_pkg::*;
#(
  parameter int W = BYTE_W,
  localparam int CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         rise_i,
  input  logic         si_i,
  output logic         cnt_zero_o,
  output logic [W-1:0] byte_o,
  output logic         done_o
);
  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sr_q;
  logic [W-1:0]  byte_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (run_i && rise_i) begin
        sr_q <= {sr_q[W-3:0], si_i};
        if (cnt_q == CW'(W-1)) begin
          cnt_q  <= '0;
          byte_q <= {sr_q, si_i};
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_zero_o = (cnt_q == '0);
  assign byte_o     = byte_q;
  assign done_o     = done_q;
endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
module spi_tx_shift
  import spi_hold_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] tx_i,
  output logic         so_o
);
  logic [W-2:0] sr_q;
  logic         so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else if (clr_i) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else if (run_i && fall_i) begin
      if (load_i) begin
        so_q <= tx_i[W-1];
        sr_q <= tx_i[W-2:0];
      end else begin
        so_q <= sr_q[W-2];
        sr_q <= {sr_q[W-3:0], 1'b0};
      end
    end
  end

  assign so_o = so_q;
endmodule

// File: rtl/spi_hold_front.sv
`timescale 1ns/1ps
module spi_hold_front
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-3:0] ADDR_HI = 6'b101000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              cs_ni,
  input  logic              hold_ni,
  input  logic [1:0]        addr_strap_i,
  input  logic              wp_ni,
  input  logic              rd_active_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_vld_o,
  output logic              addr_match_o,
  output logic              wp_block_o
);
  // cs resets to 0 so a pin already low at reset release is not taken as a fall
  localparam logic [PIN_N-1:0] PIN_RST = 5'b10010;

  logic [PIN_N-1:0]    lvl;
  logic [PIN_EDGE-1:0] prv;
  logic sck_rise, sck_fall, hold_chg, cs_fall;
  logic armed_q, sel, clr, run;
  logic pause_q;
  logic cnt_zero, rx_done;
  logic [BYTE_W-1:0] rx_byte;
  logic addr_done_q, match_q, drop_q, oe_q;

  spi_sync #(
    .W(PIN_N), .STAGES(SYNC_STAGES), .EW(PIN_EDGE), .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wp_ni, si_i, cs_ni, hold_ni, sck_i}),
    .q_o   (lvl),
    .prev_o(prv)
  );

  assign sck_rise = lvl[PIN_SCK] & ~prv[PIN_SCK];
  assign sck_fall = ~lvl[PIN_SCK] & prv[PIN_SCK];
  assign hold_chg = lvl[PIN_HOLD] ^ prv[PIN_HOLD];
  assign cs_fall  = ~lvl[PIN_CS] & prv[PIN_CS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (cs_fall) armed_q <= 1'b1;
  end

  assign sel = armed_q & ~lvl[PIN_CS];
  assign clr = ~sel;
  assign run = sel & ~pause_q & ~drop_q;

  spi_pause_ctl u_pause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .sck_lvl_i (lvl[PIN_SCK]),
    .hold_lvl_i(lvl[PIN_HOLD]),
    .hold_chg_i(hold_chg),
    .pause_o   (pause_q)
  );

  spi_rx_shift #(.W(BYTE_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .run_i     (run),
    .rise_i    (sck_rise),
    .si_i      (lvl[PIN_SI]),
    .cnt_zero_o(cnt_zero),
    .byte_o    (rx_byte),
    .done_o    (rx_done)
  );

  spi_tx_shift #(.W(BYTE_W)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (run & match_q),
    .fall_i(sck_fall),
    .load_i(cnt_zero),
    .tx_i  (tx_byte_i),
    .so_o  (so_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_done_q <= 1'b0;
      match_q     <= 1'b0;
      drop_q      <= 1'b0;
    end else if (clr) begin
      addr_done_q <= 1'b0;
      match_q     <= 1'b0;
      drop_q      <= 1'b0;
    end else if (rx_done && !addr_done_q) begin
      addr_done_q <= 1'b1;
      if (rx_byte == {ADDR_HI, addr_strap_i}) match_q <= 1'b1;
      else                                     drop_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= sel & match_q & rd_active_i & ~pause_q;
  end

  assign so_oe_o      = oe_q;
  assign rx_byte_o    = rx_byte;
  assign rx_vld_o     = rx_done & match_q;
  assign addr_match_o = match_q;
  assign wp_block_o   = ~lvl[PIN_WP];
endmodule

// File: rtl/spi_hold_front_chk.sv
`timescale 1ns/1ps
module spi_hold_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_vld_o,
  input logic addr_match_o,
  input logic so_oe_o,
  input logic rd_active_i,
  input logic pause_i
);
  p_vld_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |=> !rx_vld_o);

  p_vld_needs_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> addr_match_o);

  p_oe_needs_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_match_o |-> !so_oe_o);

  p_pause_no_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !rx_vld_o);

  p_pause_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !so_oe_o);

  p_oe_needs_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_active_i |=> !so_oe_o);
endmodule

bind spi_hold_front spi_hold_front_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_vld_o    (rx_vld_o),
  .addr_match_o(addr_match_o),
  .so_oe_o     (so_oe_o),
  .rd_active_i (rd_active_i),
  .pause_i     (pause_q)
);

// File: tb/sim_spi_hold_front.sv
`timescale 1ns/1ps
module sim_spi_hold_front;
  localparam int H = 8;
  localparam logic [5:0] AHI = 6'b101000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0, sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic wp_n = 1'b1, rd_act = 1'b0;
  logic [7:0] tx_b = 8'h00;
  logic so, so_oe, rx_vld, match, wp_blk;
  logic [7:0] rx_b;

  spi_hold_front #(.ADDR_HI(AHI)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .si_i(si), .cs_ni(cs_n),
    .hold_ni(hold_n), .addr_strap_i(strap), .wp_ni(wp_n), .rd_active_i(rd_act),
    .tx_byte_i(tx_b), .so_o(so), .so_oe_o(so_oe), .rx_byte_o(rx_b),
    .rx_vld_o(rx_vld), .addr_match_o(match), .wp_block_o(wp_blk)
  );

  int n_chk = 0, n_err = 0, n_got = 0;
  logic [7:0] got [64];
  logic [7:0] exp_q [8];
  bit finished = 0;

  always @(negedge clk) if (rst_ni && rx_vld) begin
    if (n_got < 64) got[n_got] = rx_b;
    n_got++;
  end

  function automatic logic [7:0] dev_addr(input logic [1:0] s);
    return {AHI, s};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode: 0 plain, 1 pause after bit, 2 hold drop in SCK high, 3 hold raise in SCK high
  task automatic bit_x(input logic b, input int mode, output logic so_s);
    si = b;
    tick(H);
    so_s = so;
    sck = 1'b1;
    if (mode == 2 || mode == 3) begin
      tick(H/2);
      hold_n = (mode == 3);
      tick(H/2);
    end else tick(H);
    sck = 1'b0;
    if (mode == 1) begin
      tick(H);
      hold_n = 1'b0;
      tick(H);
      chk(!so_oe, "R9 oe low in pause", so_oe, 0);
      for (int k = 0; k < 3; k++) begin
        si = 1'($urandom);
        sck = 1'b1; tick(H);
        sck = 1'b0; tick(H);
      end
      hold_n = 1'b1;
      tick(H);
    end
  endtask

  task automatic byte_x(input logic [7:0] b, input int pause_at, input bit ign,
                        output logic [7:0] so_b);
    for (int i = 7; i >= 0; i--) begin
      int mode;
      logic s;
      mode = 0;
      if (7 - i == pause_at) mode = 1;
      else if (ign && 7 - i == 2) mode = 2;
      else if (ign && 7 - i == 5) mode = 3;
      bit_x(b[i], mode, s);
      so_b[i] = s;
    end
  endtask

  task automatic begin_t;
    n_got = 0;
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic end_t;
    tick(H);
    cs_n = 1'b1;
    tick(H);
  endtask

  task automatic cmp_bytes(input int n, input string tag);
    chk(n_got == n, {tag, " byte count"}, n_got, n);
    for (int i = 0; i < n && i < n_got; i++)
      chk(got[i] == exp_q[i], tag, got[i], exp_q[i]);
  endtask

  initial begin
    logic [7:0] sob, addr, d;
    tick(5);
    rst_ni = 1'b1;
    tick(4);
    chk(!so_oe, "R5 reset oe", so_oe, 0);
    chk(!rx_vld, "R1 reset vld", rx_vld, 0);
    chk(!match, "R2 reset match", match, 0);
    chk(!wp_blk, "R10 reset wp", wp_blk, 0);

    // R4: cs low across reset release, traffic must be ignored
    n_got = 0;
    byte_x(dev_addr(strap), -1, 0, sob);
    byte_x(8'h5A, -1, 0, sob);
    chk(n_got == 0, "R4 unarmed strobes", n_got, 0);
    chk(!match, "R4 unarmed match", match, 0);
    end_t();

    // R1/R2 plain write
    begin_t();
    byte_x(dev_addr(strap), -1, 0, sob);
    chk(n_got == 0, "R2 address not strobed", n_got, 0);
    exp_q[0] = 8'hC3; exp_q[1] = 8'h01;
    byte_x(exp_q[0], -1, 0, sob);
    byte_x(exp_q[1], -1, 0, sob);
    chk(match, "R2 match held", match, 1);
    chk(!so_oe, "R9 oe low without read", so_oe, 0);
    cmp_bytes(2, "R1 write bytes");
    end_t();
    chk(!match, "R5 match cleared", match, 0);

    // R3 mismatch
    begin_t();
    rd_act = 1'b1;
    byte_x(dev_addr(strap ^ 2'b01), -1, 0, sob);
    byte_x(8'hFF, -1, 0, sob);
    chk(!match, "R3 mismatch flag", match, 0);
    chk(!so_oe, "R3 oe after mismatch", so_oe, 0);
    chk(n_got == 0, "R3 no strobes", n_got, 0);
    rd_act = 1'b0;
    end_t();

    // R5 cs high mid byte
    begin_t();
    byte_x(dev_addr(strap), -1, 0, sob);
    for (int i = 0; i < 3; i++) begin logic s; bit_x(1'b1, 0, s); end
    end_t();
    chk(!so_oe && !match, "R5 deselect clears", {so_oe, match}, 0);
    begin_t();
    byte_x(dev_addr(strap), -1, 0, sob);
    exp_q[0] = 8'h96;
    byte_x(exp_q[0], -1, 0, sob);
    cmp_bytes(1, "R5 realigned byte");
    end_t();

    // R6 pause mid byte, R7 ignored hold edges
    begin_t();
    byte_x(dev_addr(strap), -1, 0, sob);
    exp_q[0] = 8'hA5; exp_q[1] = 8'h3C;
    byte_x(exp_q[0], 3, 0, sob);
    byte_x(exp_q[1], -1, 1, sob);
    cmp_bytes(2, "R6 R7 pause bytes");
    end_t();

    // R8 read with pause
    tx_b = 8'hB4;
    rd_act = 1'b1;
    begin_t();
    byte_x(dev_addr(strap), -1, 0, sob);
    byte_x(8'h00, -1, 0, sob);
    chk(sob == tx_b, "R8 read byte", sob, tx_b);
    chk(so_oe, "R9 oe high in read", so_oe, 1);
    byte_x(8'h00, 4, 0, sob);
    chk(sob == tx_b, "R8 R6 read across pause", sob, tx_b);
    end_t();
    chk(!so_oe, "R5 oe off at deselect", so_oe, 0);
    rd_act = 1'b0;

    // R10
    wp_n = 1'b0; tick(5);
    chk(wp_blk, "R10 wp low", wp_blk, 1);
    wp_n = 1'b1; tick(5);
    chk(!wp_blk, "R10 wp high", wp_blk, 0);

    // random mix
    void'($urandom(32'd1234));
    for (int t = 0; t < 20; t++) begin
      int nb, pa;
      bit ok, ign;
      logic [1:0] sv;
      sv = 2'($urandom);
      strap = sv;
      ok = ($urandom % 4) != 0;
      addr = ok ? dev_addr(sv) : dev_addr(sv) ^ (8'h01 << ($urandom % 8));
      nb = 1 + $urandom % 3;
      rd_act = 1'($urandom);
      tx_b = 8'($urandom);
      tick(4);
      begin_t();
      byte_x(addr, -1, 0, sob);
      for (int i = 0; i < nb; i++) begin
        d = 8'($urandom);
        exp_q[i] = d;
        pa = int'($urandom % 12) - 4;
        ign = (pa < 0) && 1'($urandom);
        byte_x(d, pa, ign, sob);
        if (ok && rd_act) chk(sob == tx_b, "R8 random read", sob, tx_b);
      end
      chk(match == ok, "R2 random match", match, ok);
      if (ok) cmp_bytes(nb, "R1 random bytes");
      else chk(n_got == 0, "R3 random mismatch", n_got, 0);
      end_t();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule